// File: doc/BRIEF.md
# Aligned Power-of-Two Range Splitter

This block cuts one address region into a run of naturally aligned windows whose sizes are powers of two. Each window is emitted as a tuple: a match address, a remap address and a mask, plus a transaction type. These tuples are meant to be loaded into an outbound address translation table. A region is given by its start address on the system side, its size in bytes, the offset between system and link addresses, and a flag that marks it as I/O or memory.

The controller first loads the region, then produces at most one window per clock cycle. Each window is the largest aligned block that fits at the current start. Splitting stops when the region is covered, when the shared table budget is used up, when the next window would be smaller than the minimum size, or when the remap address is not aligned to the window. A running window count goes in and comes out, so that several regions, handled one after another, share one table. A memory region with zero offset needs no translation, so it is passed through with no windows.

The FSM has three states. IDLE waits for a request. SPLIT emits one window per cycle. FIN raises done for one cycle. The transitions are:
- IDLE→SPLIT on start, for a region that needs windows.
- IDLE→FIN on start, for a memory region with zero offset.
- SPLIT→SPLIT when a window is accepted.
- SPLIT→FIN when the region is covered or a stop rule fires.
- FIN→IDLE unconditionally.

Top module: `range_window_splitter`

## Requirements
- R1: Each window's size is the lowest set bit of (the highest set bit of the remaining size OR the lowest set bit of the current start). When the start is zero, only the size term counts. The match address equals the current start and is therefore aligned to the window size.
- R2: If the computed window size is below 2^MIN_LOG2 (64 KiB by default), splitting stops and no window is emitted for that step.
- R3: For every window, remap = start − offset and mask = NOT(size − 1).
- R4: If the remap address has any bit set below the window size, splitting stops and that window is neither emitted nor counted.
- R5: After each accepted window, the start advances by the window size and the remaining size shrinks by the same amount. The windows therefore tile the region in ascending order.
- R6: The total window count, starting from count_in, never exceeds MAX_WIN (8). When the count reaches MAX_WIN, splitting stops. count_out gives the running total.
- R7: If any size remains when splitting stops, error_o is high with done_o.
- R8: A memory region (is_io=0) with zero offset ends with done and no windows. Its error is low and count_out equals count_in.
- R9: The window type is 4'h4 for I/O regions and 4'h0 for memory regions.
- R10: A start seen in IDLE makes busy_o high from the next cycle. Accepted windows appear as single-cycle win_valid_o strobes. done_o is a one-cycle pulse. error_o is updated with done_o and holds until the next start.
- R11: After reset, busy_o, done_o, win_valid_o and error_o are low and count_out is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin splitting a region (sampled in IDLE) |
| is_io_i | input | 1 | 1 = I/O region, 0 = memory region |
| base_i | input | AW | System-side start address of the region |
| size_i | input | AW | Region size in bytes |
| offset_i | input | AW | System address minus link address |
| count_in_i | input | CW | Windows already used by earlier regions |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Region not fully covered |
| win_valid_o | output | 1 | Window tuple valid this cycle |
| win_match_o | output | AW | Window match address |
| win_remap_o | output | AW | Window remap (link) address |
| win_mask_o | output | AW | Window mask |
| win_type_o | output | 4 | Transaction type code |
| count_out_o | output | CW | Running window count |

## Verification
The assertions check, on every cycle, properties that hold for each window taken alone:
- match and remap are aligned to the mask, and the mask never exposes bits below the minimum size;
- the type code is one of the two legal values;
- the count stays within the budget;
- done is a single pulse, and error only rises with done.

Whether the split is the right one can only be shown by the bench's scenarios. This covers the sequence of window sizes, the contiguous tiling, the stop point for leftovers, budget exhaustion across regions, and the zero-offset memory skip.

// File: rtl/rws_pkg.sv
package rws_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SPLIT = 2'd1,
        ST_FIN   = 2'd2
    } rws_state_e;

    localparam logic [3:0] TYPE_MEM = 4'h0;
    localparam logic [3:0] TYPE_IO  = 4'h4;
endpackage

// File: rtl/rws_winsize.sv
module rws_winsize #(
    parameter int AW = 40
) (
    input  logic [AW-1:0] cur_base_i,
    input  logic [AW-1:0] rem_size_i,
    output logic [AW-1:0] win_o
);
    logic [AW-1:0] size_top;
    logic [AW-1:0] base_low;
    logic [AW-1:0] combined;

    // highest set bit of the remaining size, as a one-hot value
    always_comb begin
        size_top = '0;
        for (int i = 0; i < AW; i++) begin
            if (rem_size_i[i]) size_top = {{(AW-1){1'b0}}, 1'b1} << i;
        end
    end

    assign base_low = cur_base_i & (~cur_base_i + {{(AW-1){1'b0}}, 1'b1});
    assign combined = size_top | base_low;
    assign win_o    = combined & (~combined + {{(AW-1){1'b0}}, 1'b1});
endmodule

// File: rtl/rws_tuple.sv
module rws_tuple #(
    parameter int AW = 40
) (
    input  logic [AW-1:0] cur_base_i,
    input  logic [AW-1:0] offset_i,
    input  logic [AW-1:0] win_i,
    input  logic          is_io_i,
    output logic [AW-1:0] match_o,
    output logic [AW-1:0] remap_o,
    output logic [AW-1:0] mask_o,
    output logic [3:0]    type_o,
    output logic          remap_ok_o
);
    import rws_pkg::*;

    logic [AW-1:0] low_bits;

    assign low_bits   = win_i - {{(AW-1){1'b0}}, 1'b1};
    assign match_o    = cur_base_i;
    assign remap_o    = cur_base_i - offset_i;
    assign mask_o     = ~low_bits;
    assign type_o     = is_io_i ? TYPE_IO : TYPE_MEM;
    assign remap_ok_o = (remap_o & low_bits) == '0;
endmodule

// File: rtl/range_window_splitter.sv
module range_window_splitter #(
    parameter int AW       = 40,
    parameter int MIN_LOG2 = 16,
    parameter int MAX_WIN  = 8,
    parameter int CW       = $clog2(MAX_WIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          is_io_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] size_i,
    input  logic [AW-1:0] offset_i,
    input  logic [CW-1:0] count_in_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          error_o,
    output logic          win_valid_o,
    output logic [AW-1:0] win_match_o,
    output logic [AW-1:0] win_remap_o,
    output logic [AW-1:0] win_mask_o,
    output logic [3:0]    win_type_o,
    output logic [CW-1:0] count_out_o
);
    import rws_pkg::*;

    localparam logic [AW-1:0] MIN_WIN = {{(AW-1){1'b0}}, 1'b1} << MIN_LOG2;
    localparam logic [CW-1:0] CNT_MAX = CW'(MAX_WIN);

    rws_state_e    state_q, state_d;
    logic [AW-1:0] base_q, rem_q, off_q;
    logic          io_q;
    logic [CW-1:0] cnt_q;

    logic [AW-1:0] win;
    logic [AW-1:0] t_match, t_remap, t_mask;
    logic [3:0]    t_type;
    logic          t_remap_ok;
    logic          table_full, too_small, accept, skip_req;

    rws_winsize #(.AW(AW)) u_winsize (
        .cur_base_i (base_q),
        .rem_size_i (rem_q),
        .win_o      (win)
    );

    rws_tuple #(.AW(AW)) u_tuple (
        .cur_base_i (base_q),
        .offset_i   (off_q),
        .win_i      (win),
        .is_io_i    (io_q),
        .match_o    (t_match),
        .remap_o    (t_remap),
        .mask_o     (t_mask),
        .type_o     (t_type),
        .remap_ok_o (t_remap_ok)
    );

    assign table_full = cnt_q >= CNT_MAX;
    assign too_small  = win < MIN_WIN;
    assign accept     = (state_q == ST_SPLIT) && (rem_q != '0) && !table_full
                        && !too_small && t_remap_ok;
    assign skip_req   = !is_io_i && (offset_i == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = skip_req ? ST_FIN : ST_SPLIT;
            ST_SPLIT: if (!accept) state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // region datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            rem_q  <= '0;
            off_q  <= '0;
            io_q   <= 1'b0;
            cnt_q  <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            base_q <= base_i;
            rem_q  <= size_i;
            off_q  <= offset_i;
            io_q   <= is_io_i;
            cnt_q  <= count_in_i;
        end else if (accept) begin
            base_q <= base_q + win;
            rem_q  <= rem_q - win;
            cnt_q  <= cnt_q + {{(CW-1){1'b0}}, 1'b1};
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_valid_o <= 1'b0;
            win_match_o <= '0;
            win_remap_o <= '0;
            win_mask_o  <= '0;
            win_type_o  <= TYPE_MEM;
            error_o     <= 1'b0;
        end else begin
            win_valid_o <= accept;
            if (accept) begin
                win_match_o <= t_match;
                win_remap_o <= t_remap;
                win_mask_o  <= t_mask;
                win_type_o  <= t_type;
            end
            if (state_q == ST_IDLE && start_i)
                error_o <= 1'b0;
            else if (state_q == ST_SPLIT && !accept)
                error_o <= rem_q != '0;
        end
    end

    assign busy_o      = state_q != ST_IDLE;
    assign done_o      = state_q == ST_FIN;
    assign count_out_o = cnt_q;
endmodule

// File: rtl/rws_checker.sv
module rws_checker #(
    parameter int AW       = 40,
    parameter int MIN_LOG2 = 16,
    parameter int MAX_WIN  = 8,
    parameter int CW       = $clog2(MAX_WIN + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy_o,
    input logic          done_o,
    input logic          error_o,
    input logic          win_valid_o,
    input logic [AW-1:0] win_match_o,
    input logic [AW-1:0] win_remap_o,
    input logic [AW-1:0] win_mask_o,
    input logic [3:0]    win_type_o,
    input logic [CW-1:0] count_out_o
);
    // R1
    match_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o |-> (win_match_o & ~win_mask_o) == '0);
    // R2
    min_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o |-> win_mask_o[MIN_LOG2-1:0] == '0);
    // R4
    remap_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o |-> (win_remap_o & ~win_mask_o) == '0);
    // R6
    budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o |-> count_out_o <= CW'(MAX_WIN));
    // R9
    type_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o |-> (win_type_o == 4'h0 || win_type_o == 4'h4));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R10
    valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o |-> busy_o);
    // R7
    error_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error_o) |-> done_o);
endmodule

bind range_window_splitter rws_checker #(
    .AW(AW), .MIN_LOG2(MIN_LOG2), .MAX_WIN(MAX_WIN), .CW(CW)
) u_rws_checker (
    .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
    .error_o(error_o), .win_valid_o(win_valid_o), .win_match_o(win_match_o),
    .win_remap_o(win_remap_o), .win_mask_o(win_mask_o),
    .win_type_o(win_type_o), .count_out_o(count_out_o)
);

// File: tb/range_window_splitter_bench.sv
module range_window_splitter_bench;
    localparam int AW = 40;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          is_io_i = 1'b0;
    logic [AW-1:0] base_i = '0, size_i = '0, offset_i = '0;
    logic [CW-1:0] count_in_i = '0;
    logic          busy_o, done_o, error_o, win_valid_o;
    logic [AW-1:0] win_match_o, win_remap_o, win_mask_o;
    logic [3:0]    win_type_o;
    logic [CW-1:0] count_out_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    range_window_splitter u_range_window_splitter (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_io_i(is_io_i),
        .base_i(base_i), .size_i(size_i), .offset_i(offset_i),
        .count_in_i(count_in_i), .busy_o(busy_o), .done_o(done_o),
        .error_o(error_o), .win_valid_o(win_valid_o),
        .win_match_o(win_match_o), .win_remap_o(win_remap_o),
        .win_mask_o(win_mask_o), .win_type_o(win_type_o),
        .count_out_o(count_out_o)
    );

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] size;
        logic [AW-1:0] off;
        logic          io;
        logic [3:0]    cin;
        logic [3:0]    n;
        logic          err;
        logic [3:0]    cout;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{40'h00_8000_0000, 40'h00_0100_0000, 40'h00_4000_0000, 1'b0, 4'd0, 4'd1, 1'b0, 4'd1},
        '{40'h00_8000_0000, 40'h00_0100_0000, 40'h00_0000_0000, 1'b0, 4'd3, 4'd0, 1'b0, 4'd3},
        '{40'h00_0001_0000, 40'h00_0003_0000, 40'h00_0000_0000, 1'b1, 4'd0, 4'd2, 1'b0, 4'd2},
        '{40'h00_2000_0000, 40'h00_0001_8000, 40'h00_1000_0000, 1'b0, 4'd0, 4'd1, 1'b1, 4'd1},
        '{40'h00_0010_0000, 40'h00_0010_0000, 40'h00_0000_8000, 1'b0, 4'd0, 4'd0, 1'b1, 4'd0},
        '{40'h00_0001_0000, 40'h00_0003_0000, 40'h00_0000_0000, 1'b1, 4'd7, 4'd1, 1'b1, 4'd8},
        '{40'h00_0001_0000, 40'h00_0001_0000, 40'h00_0000_0000, 1'b1, 4'd8, 4'd0, 1'b1, 4'd8},
        '{40'h00_0000_0000, 40'h00_0005_0000, 40'h00_0000_0000, 1'b1, 4'd0, 4'd2, 1'b0, 4'd2},
        '{40'h00_0004_0000, 40'h00_0000_0000, 40'h00_0000_0000, 1'b1, 4'd2, 4'd0, 1'b0, 4'd2}
    };

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] lowbit(input logic [AW-1:0] x);
        return x & (~x + 1'b1);
    endfunction

    function automatic logic [AW-1:0] highbit(input logic [AW-1:0] x);
        logic [AW-1:0] r = '0;
        for (int i = 0; i < AW; i++) if (x[i]) r = {{(AW-1){1'b0}}, 1'b1} << i;
        return r;
    endfunction

    task automatic run_vec(input vec_t v);
        logic [AW-1:0] mb = v.base;
        logic [AW-1:0] w;
        int            seen = 0;
        bit            finished = 0;
        @(negedge clk);
        start_i = 1'b1; is_io_i = v.io; base_i = v.base; size_i = v.size;
        offset_i = v.off; count_in_i = v.cin;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
        for (int c = 0; c < 20 && !finished; c++) begin
            if (win_valid_o) begin
                w = lowbit(highbit(v.size - (mb - v.base)) | lowbit(mb));
                chk(win_match_o == mb, "R1/R5 match", win_match_o, mb);
                chk(win_mask_o == ~(w - 1'b1), "R1 R3 mask", win_mask_o, ~(w - 1'b1));
                chk(win_remap_o == mb - v.off, "R3 remap", win_remap_o, mb - v.off);
                chk(win_type_o == (v.io ? 4'h4 : 4'h0), "R9 type", win_type_o,
                    v.io ? 4'h4 : 4'h0);
                mb = mb + w;
                seen++;
            end
            if (done_o) finished = 1;
            else @(negedge clk);
        end
        chk(finished, "R10 done reached", finished, 1);
        chk(seen == v.n, "R2 R4 R6 window count", seen, v.n);
        chk(error_o == v.err, "R7 error", error_o, v.err);
        chk(count_out_o == v.cout, "R6 R8 count_out", count_out_o, v.cout);
        @(negedge clk);
        chk(done_o == 1'b0, "R10 done pulse", done_o, 0);
        chk(error_o == v.err, "R10 error held", error_o, v.err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R11 reset state
        chk(!busy_o && !done_o && !win_valid_o && !error_o, "R11 reset outputs",
            {busy_o, done_o, win_valid_o, error_o}, 0);
        chk(count_out_o == '0, "R11 reset count", count_out_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o, "R11 idle after reset", busy_o, 0);
        for (int k = 0; k < NV; k++) run_vec(VECS[k]);
        // R8 skip: no strobe within the whole request
        @(negedge clk);
        start_i = 1'b1; is_io_i = 1'b0; base_i = 40'h10_0000_0000;
        size_i = 40'h1_0000_0000; offset_i = '0; count_in_i = 4'd5;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o && !win_valid_o, "R8 immediate done", {done_o, win_valid_o}, 2'b10);
        chk(count_out_o == 4'd5 && !error_o, "R8 count kept", count_out_o, 5);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule